// File: doc/BRIEF.md
# Table-Driven Disk Read/Write Sequencer

This block is the bit-level engine of a floppy disk controller. On every clock in which it is allowed to run, it builds a lookup address from its own state and from live inputs. The inputs are the write-mode flag, the command flag, the top bit of its shift register and a stretched flux flag. It fetches the next state from a 256-entry microcode table. The low nibble of that new state picks what happens to an 8-bit shift register: hold, shift in a zero or a one, shift right bringing in write-protect status, load from a data bus, or clear.

In write mode the block also emits a one-cycle flux transition each time bit 7 of the state changes from one step to the next. Each flux event from the drive is stretched into an active-low flag that stays low for a fixed number of clocks. The table is filled through a simple address/data/write-enable port while the sequencer is held idle with `run` low.

Top module: `disk_seq`

## Requirements
- R1: After synchronous reset the state and shift register read 0, `wr_flux` is 0 and `flux_n` is 1.
- R2: When `run` is high, the next state is the table entry at address {state[7:4], wmode, cmd, shreg[7], flux_n}, with bit 7 as the MSB. Bit 3 of the address is `wmode`, bit 2 is `cmd`, bit 1 is the shift register MSB and bit 0 is the flux flag.
- R3: Action code 0x8 (the new state's low nibble) leaves the shift register unchanged.
- R4: Action 0x9 shifts the register left and brings in 0. Action 0xD shifts it left and brings in 1.
- R5: Action 0xA shifts the register right and places `wprot` in bit 7.
- R6: Action 0xB loads the shift register from `din`.
- R7: Any other action code clears the shift register to 0.
- R8: `wr_flux` is 1 in the cycle after a step taken with `wmode` high in which bit 7 of the new state differs from bit 7 of the old state. In every other case it is 0.
- R9: A `flux_evt` sampled high drives `flux_n` low for exactly FLUX_HOLD (default 2) cycles, after which it returns high. A new event restarts the count.
- R10: While `run` is low, the state and shift register hold, and table writes take effect. Table writes presented while `run` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Sequencer step enable; low holds it idle |
| wmode | input | 1 | Write-mode flag (address bit 3) |
| cmd | input | 1 | Command flag (address bit 2) |
| wprot | input | 1 | Write-protect status for action 0xA |
| din | input | DATA_W | Data bus for action 0xB |
| flux_evt | input | 1 | One-cycle flux event from the drive |
| tbl_we | input | 1 | Table write enable (honoured only when idle) |
| tbl_addr | input | ADDR_W | Table write address |
| tbl_data | input | DATA_W | Table write data |
| seq_state | output | DATA_W | Current state register |
| shreg | output | DATA_W | Shift register |
| wr_flux | output | 1 | Registered write flux transition |
| flux_n | output | 1 | Stretched active-low flux flag |

## Verification
The sequencer runs from pseudo-random tables whose action nibbles cover all sixteen codes. It runs first in read mode with sparse flux events, then in write mode, then with the command flag set. This separates the address bit ordering, because a swapped flag bit fetches a different entry and the state diverges. A second table made mostly of shift actions exercises long shift chains where the MSB feeds back into the address. Idle stretches with writes, and writes attempted while running, separate the table-load gating from the hold behaviour. Back-to-back flux events check that the pulse restarts.

// File: rtl/disk_seq_pkg.sv
package disk_seq_pkg;
  typedef enum logic [3:0] {
    ACT_HOLD  = 4'h8,
    ACT_SHL0  = 4'h9,
    ACT_SHRWP = 4'hA,
    ACT_LOAD  = 4'hB,
    ACT_SHL1  = 4'hD
  } seq_act_e;

  function automatic int clog2_min1(input int v);
    int r;
    r = 1;
    while ((1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/dseq_table.sv
module dseq_table #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dseq_flux.sv
module dseq_flux #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  output logic flag_n
);
  localparam int CW = disk_seq_pkg::clog2_min1(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      flag_n <= 1'b1;
    end else if (evt) begin
      cnt    <= CW'(HOLD);
      flag_n <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) flag_n <= 1'b1;
    end
  end

  p_low_after_evt_r9: assert property (@(posedge clk) disable iff (rst)
    evt |=> !flag_n);
  p_low_while_count_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt > CW'(1)) |=> !flag_n);
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(1) && !evt) |=> flag_n);
endmodule

// File: rtl/dseq_shift.sv
module dseq_shift
  import disk_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [3:0]        act,
  input  logic              wprot,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] sr
);
  logic [DATA_W-1:0] sr_nxt;

  always_comb begin
    unique case (act)
      ACT_HOLD:  sr_nxt = sr;
      ACT_SHL0:  sr_nxt = {sr[DATA_W-2:0], 1'b0};
      ACT_SHL1:  sr_nxt = {sr[DATA_W-2:0], 1'b1};
      ACT_SHRWP: sr_nxt = {wprot, sr[DATA_W-1:1]};
      ACT_LOAD:  sr_nxt = din;
      default:   sr_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       sr <= '0;
    else if (step) sr <= sr_nxt;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (step && act == ACT_HOLD) |=> $stable(sr));
  p_shl1_r4: assert property (@(posedge clk) disable iff (rst)
    (step && act == ACT_SHL1) |=> sr[0]);
  p_shr_wp_r5: assert property (@(posedge clk) disable iff (rst)
    (step && act == ACT_SHRWP) |=> sr[DATA_W-1] == $past(wprot));
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    (step && act == ACT_LOAD) |=> sr == $past(din));
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (step && act[3] == 1'b0) |=> sr == '0);
endmodule

// File: rtl/disk_seq.sv
module disk_seq #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = DATA_W / 2 + 4,
  parameter int FLUX_HOLD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wmode,
  input  logic              cmd,
  input  logic              wprot,
  input  logic [DATA_W-1:0] din,
  input  logic              flux_evt,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [DATA_W-1:0] tbl_data,
  output logic [DATA_W-1:0] seq_state,
  output logic [DATA_W-1:0] shreg,
  output logic              wr_flux,
  output logic              flux_n
);
  localparam int NIB = DATA_W / 2;

  logic [ADDR_W-1:0] look_addr;
  logic [DATA_W-1:0] nxt_state;
  logic              load_ok;

  assign look_addr = {seq_state[DATA_W-1 -: NIB], wmode, cmd, shreg[DATA_W-1], flux_n};
  assign load_ok   = tbl_we && !run;

  dseq_table #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_tbl (
    .clk   (clk),
    .we    (load_ok),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .raddr (look_addr),
    .rdata (nxt_state)
  );

  dseq_flux #(.HOLD(FLUX_HOLD)) u_flux (
    .clk    (clk),
    .rst    (rst),
    .evt    (flux_evt),
    .flag_n (flux_n)
  );

  dseq_shift #(.DATA_W(DATA_W)) u_sh (
    .clk   (clk),
    .rst   (rst),
    .step  (run),
    .act   (nxt_state[3:0]),
    .wprot (wprot),
    .din   (din),
    .sr    (shreg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_state <= '0;
      wr_flux   <= 1'b0;
    end else if (run) begin
      seq_state <= nxt_state;
      wr_flux   <= wmode && (nxt_state[DATA_W-1] != seq_state[DATA_W-1]);
    end else begin
      wr_flux   <= 1'b0;
    end
  end

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(seq_state) && $stable(shreg)));
  p_no_flux_read_r8: assert property (@(posedge clk) disable iff (rst)
    !wmode |=> !wr_flux);
  p_flux_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (run && wmode) |=> wr_flux == (seq_state[DATA_W-1] != $past(seq_state[DATA_W-1])));
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    run |=> seq_state == $past(nxt_state));
endmodule

// File: tb/sim_disk_seq.sv
module sim_disk_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0, wmode = 1'b0, cmd = 1'b0, wprot = 1'b0, flux_evt = 1'b0, tbl_we = 1'b0;
  logic [7:0] din = '0, tbl_addr = '0, tbl_data = '0;
  logic [7:0] seq_state, shreg;
  logic wr_flux, flux_n;

  always #2 clk = ~clk;

  disk_seq u0 (
    .clk(clk), .rst(rst), .run(run), .wmode(wmode), .cmd(cmd), .wprot(wprot),
    .din(din), .flux_evt(flux_evt), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .seq_state(seq_state), .shreg(shreg),
    .wr_flux(wr_flux), .flux_n(flux_n)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural reference
  int m_tbl[256];
  logic [7:0] m_st, m_sr;
  bit m_wf, m_fn, m_ran;
  int m_cnt, m_act;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_sr = 0; m_wf = 0; m_fn = 1; m_cnt = 0; m_ran = 0; m_act = -1;
    end else begin
      if (tbl_we && !run) m_tbl[tbl_addr] = tbl_data;
      m_ran = run;
      if (run) begin
        int a;
        logic [7:0] ns;
        a  = m_st[7:4] * 16 + wmode * 8 + cmd * 4 + m_sr[7] * 2 + m_fn;
        ns = 8'(m_tbl[a]);
        m_act = ns[3:0];
        case (m_act)
          8:  ;
          9:  m_sr = m_sr << 1;
          13: m_sr = (m_sr << 1) | 8'h01;
          10: m_sr = (m_sr >> 1) | (wprot ? 8'h80 : 8'h00);
          11: m_sr = din;
          default: m_sr = 0;
        endcase
        m_wf = wmode && (ns[7] != m_st[7]);
        m_st = ns;
      end else begin
        m_wf = 0;
      end
      if (flux_evt) begin m_fn = 0; m_cnt = 2; end
      else if (m_cnt > 0) begin m_cnt--; if (m_cnt == 0) m_fn = 1; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string sr_tag();
    if (!m_ran) return "R10";
    case (m_act)
      8: return "R3";
      9, 13: return "R4";
      10: return "R5";
      11: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare_all();
    chk(seq_state == m_st, m_ran ? "R2 state" : "R10 state", seq_state, m_st);
    chk(shreg == m_sr, sr_tag(), shreg, m_sr);
    chk(wr_flux == m_wf, "R8 wr_flux", wr_flux, m_wf);
    chk(flux_n == m_fn, "R9 flux_n", flux_n, m_fn);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic load_table(input int kind);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      compare_all();
      run = 0; tbl_we = 1; tbl_addr = 8'(a);
      lfsr = nxt(lfsr);
      if (kind == 0) tbl_data = 8'(a * 37 + 11) ^ lfsr[7:0];
      else tbl_data = {lfsr[7:4], (lfsr[1:0] == 0) ? 4'hB : (lfsr[0] ? 4'hD : 4'h9)};
      din = lfsr[15:8];
    end
    @(negedge clk); compare_all(); tbl_we = 0;
  endtask

  task automatic run_phase(input int n, input bit wm, input int cmd_mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      lfsr = nxt(lfsr);
      run      = (lfsr[3:0] != 0);
      wmode    = wm;
      cmd      = (cmd_mode == 2) ? lfsr[5] : cmd_mode[0];
      wprot    = lfsr[6];
      din      = lfsr[15:8];
      flux_evt = (lfsr[9:7] == 0);
      // R10: writes while running must be ignored; idle writes land
      tbl_we   = lfsr[11];
      tbl_addr = lfsr[7:0] ^ lfsr[15:8];
      tbl_data = lfsr[15:8] + 8'h5A;
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(seq_state == 0, "R1 state", seq_state, 0);
    chk(shreg == 0, "R1 shreg", shreg, 0);
    chk(wr_flux == 0, "R1 wr_flux", wr_flux, 0);
    chk(flux_n == 1, "R1 flux_n", flux_n, 1);

    load_table(0);
    // directed R9: single event, low for 2 cycles then high
    @(negedge clk); flux_evt = 1;
    @(negedge clk); flux_evt = 0; chk(flux_n == 0, "R9 low1", flux_n, 0);
    @(negedge clk); chk(flux_n == 0, "R9 low2", flux_n, 0);
    @(negedge clk); chk(flux_n == 1, "R9 release", flux_n, 1);
    // R9 retrigger
    flux_evt = 1; @(negedge clk); @(negedge clk); flux_evt = 0;
    chk(flux_n == 0, "R9 retrig", flux_n, 0);
    @(negedge clk); chk(flux_n == 0, "R9 retrig low", flux_n, 0);
    @(negedge clk); chk(flux_n == 1, "R9 retrig release", flux_n, 1);

    // directed R2: entry at address {0,0,0,0,1} -> 0x3B after reset (state 0, sr 0, flux 1)
    rst = 1; @(negedge clk); rst = 0;
    tbl_we = 1; tbl_addr = 8'h01; tbl_data = 8'h3B; din = 8'hC5;
    @(negedge clk); tbl_we = 0; run = 1;
    @(negedge clk); run = 0;
    chk(seq_state == 8'h3B, "R2 directed", seq_state, 8'h3B);
    chk(shreg == 8'hC5, "R6 directed", shreg, 8'hC5);

    run_phase(3000, 0, 0);
    run_phase(3000, 1, 0);
    run_phase(3000, 0, 1);
    run_phase(3000, 1, 2);
    load_table(1);
    run_phase(3000, 0, 2);
    run_phase(3000, 1, 2);
    @(negedge clk); compare_all();

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule